// File: doc/BRIEF.md
# Lamp Shutdown and Fault Status Guard

This block decides, every clock cycle, whether a backlight lamp may run. It combines an external suspend pin with a 3-bit shutdown-mode value. It also holds two fault status bits that a register interface elsewhere reads back. One mode bit shuts the lamp off unconditionally. The other two mode bits shut the lamp off only while the pin sits at one particular level. The pin is asynchronous, so it passes through a flop synchronizer before it is used.

The first status bit reports that the lamp is healthy. It drops to 0 when the lamp has been enabled for a full timeout window and no lamp-current-detected strobe has arrived. The window is measured in ticks of a slow timebase. Once this bit is 0 it stays 0, and it keeps the lamp dark. Only a forced shutdown sets it back to 1, whether that shutdown comes from the mode value or from the pin. The second status bit summarises overcurrent events. During each PWM period the block gathers the overcurrent pulses. At the period boundary it publishes the result for the period that just ended, and that value holds for the whole of the next period.

Top module: `swb_lamp_guard`

## Requirements
- R1: The lamp is forced off when any one of three conditions holds: mode bit 2 is 1; the synchronized pin is 1 and mode bit 1 is 1; or the synchronized pin is 0 and mode bit 0 is 1. When the lamp is not forced off and the lamp-ok bit is 1, `lamp_en_o` is 1. `lamp_en_o` follows a mode change at the first rising edge after the change. It follows a pin change at the third rising edge after the change, because of the two synchronizer flops.
- R2: In any cycle where the lamp is forced off, `lamp_ok_o` becomes 1 at the next edge.
- R3: Suppose the lamp is enabled and TIMEOUT_TICKS timebase ticks arrive with no current-detected strobe. Then `lamp_ok_o` falls to 0 at the edge that samples the last of those ticks. `lamp_en_o` falls one edge later.
- R4: A current-detected strobe restarts the tick count. Any cycle with `lamp_en_o` at 0 also restarts the tick count. One tick short of the window never clears `lamp_ok_o`.
- R5: Once `lamp_ok_o` is 0, it stays 0, and current-detected strobes have no effect on it, until the lamp is forced off. While it is 0, `lamp_en_o` is 0.
- R6: At a cycle with `pwm_edge_i` high, `no_oc_o` loads 0 if an overcurrent pulse came at any point in the period now ending, counting a pulse in the boundary cycle itself. It loads 1 if no pulse came. In every other cycle, `no_oc_o` holds its value.
- R7: While `rst` is high, `lamp_ok_o` and `no_oc_o` read 1, `lamp_en_o` reads 0, and the synchronizer holds pin level 0.
- R8: The overcurrent record is cleared at every boundary. A pulse in one period does not affect the value published for the period after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sus_pin_i | input | 1 | Asynchronous suspend pin |
| mode_i | input | 3 | Shutdown-mode bits: [2] hard off, [1] off while pin high, [0] off while pin low |
| cur_seen_i | input | 1 | One-cycle strobe: lamp current crossed the detection threshold |
| oc_pulse_i | input | 1 | One-cycle overcurrent pulse |
| pwm_edge_i | input | 1 | One-cycle PWM period boundary strobe |
| tick_i | input | 1 | One-cycle slow timebase tick |
| lamp_en_o | output | 1 | Lamp enable |
| lamp_ok_o | output | 1 | Lamp-out status, 1 = no lamp-out fault latched |
| no_oc_o | output | 1 | Overcurrent status, 1 = previous PWM period was clean |

## Verification
The assertions assume that `cur_seen_i`, `oc_pulse_i`, `pwm_edge_i` and `tick_i` are synchronous one-cycle strobes. They also assume that `mode_i` is synchronous to `clk`, while only `sus_pin_i` may change at any time. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It keeps the timebase ticks well apart, so the tick count is clear in every test. It checks the outputs on the falling edge, at the cycle counts given in the requirements.

// File: rtl/swb_pkg.sv
package swb_pkg;

    // Shutdown-mode bits as one struct; the bit order matches mode_i[2:0]
    typedef struct packed {
        logic hard_off;   // [2] unconditional shutdown
        logic off_pin_hi; // [1] shutdown while pin is high
        logic off_pin_lo; // [0] shutdown while pin is low
    } swb_mode_t;

    // Status bits that are read back elsewhere
    typedef struct packed {
        logic lamp_ok;
        logic no_oc;
    } swb_status_t;

    // What the lamp-out timer does in a cycle
    typedef enum logic [1:0] {
        TMR_CLEAR  = 2'd0,
        TMR_HOLD   = 2'd1,
        TMR_COUNT  = 2'd2,
        TMR_EXPIRE = 2'd3
    } swb_tmr_act_e;

    localparam swb_status_t SWB_STATUS_RST = '{lamp_ok: 1'b1, no_oc: 1'b1};

    function automatic logic swb_forced_off(input swb_mode_t m, input logic pin);
        return m.hard_off | (pin & m.off_pin_hi) | (~pin & m.off_pin_lo);
    endfunction

endpackage

// File: rtl/swb_pin_sync.sv
module swb_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/swb_mode_decode.sv
module swb_mode_decode
    import swb_pkg::*;
(
    input  swb_mode_t mode_i,
    input  logic      pin_i,
    output logic      force_off_o
);
    always_comb begin
        force_off_o = swb_forced_off(mode_i, pin_i);
    end
endmodule

// File: rtl/swb_lampout_timer.sv
module swb_lampout_timer
    import swb_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic force_off_i,
    input  logic lamp_en_i,
    input  logic cur_seen_i,
    input  logic tick_i,
    output logic lamp_ok_o
);
    localparam int CW = (TIMEOUT_TICKS < 2) ? 1 : $clog2(TIMEOUT_TICKS);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          ok_q;
    swb_tmr_act_e  act;

    always_comb begin
        if (force_off_i || !lamp_en_i || cur_seen_i) act = TMR_CLEAR;
        else if (tick_i)                             act = (cnt_q == LAST) ? TMR_EXPIRE : TMR_COUNT;
        else                                         act = TMR_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ok_q  <= 1'b1;
        end else begin
            unique case (act)
                TMR_CLEAR:  cnt_q <= '0;
                TMR_HOLD:   cnt_q <= cnt_q;
                TMR_COUNT:  cnt_q <= cnt_q + 1'b1;
                TMR_EXPIRE: cnt_q <= '0;
                default:    cnt_q <= '0;
            endcase
            if (force_off_i)             ok_q <= 1'b1;
            else if (act == TMR_EXPIRE)  ok_q <= 1'b0;
        end
    end

    assign lamp_ok_o = ok_q;

    AST_LAMPOUT_REARM: assert property (@(posedge clk) disable iff (rst)
        force_off_i |=> lamp_ok_o); // R2
    AST_LAMPOUT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(lamp_ok_o) |-> $past(tick_i && lamp_en_i && !cur_seen_i)); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R4
    AST_LAMPOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!lamp_ok_o && !force_off_i) |=> !lamp_ok_o); // R5

endmodule

// File: rtl/swb_oc_status.sv
module swb_oc_status (
    input  logic clk,
    input  logic rst,
    input  logic oc_pulse_i,
    input  logic pwm_edge_i,
    output logic no_oc_o
);
    logic seen_q;
    logic stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            stat_q <= 1'b1;
        end else if (pwm_edge_i) begin
            stat_q <= ~(seen_q | oc_pulse_i);
            seen_q <= 1'b0;
        end else if (oc_pulse_i) begin
            seen_q <= 1'b1;
        end
    end

    assign no_oc_o = stat_q;

    AST_OC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pwm_edge_i |=> $stable(no_oc_o)); // R6
    AST_OC_EDGE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (pwm_edge_i && oc_pulse_i) |=> !no_oc_o); // R6
    AST_OC_FRESH: assert property (@(posedge clk) disable iff (rst)
        (pwm_edge_i && !oc_pulse_i) |=> !seen_q); // R8

endmodule

// File: rtl/swb_lamp_guard.sv
module swb_lamp_guard
    import swb_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int TIMEOUT_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sus_pin_i,
    input  logic [2:0] mode_i,
    input  logic       cur_seen_i,
    input  logic       oc_pulse_i,
    input  logic       pwm_edge_i,
    input  logic       tick_i,
    output logic       lamp_en_o,
    output logic       lamp_ok_o,
    output logic       no_oc_o
);
    logic        pin_s;
    logic        force_off;
    logic        en_q;
    swb_mode_t   mode;
    swb_status_t stat;

    assign mode = swb_mode_t'(mode_i);

    swb_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sus_pin_i),
        .q_o (pin_s)
    );

    swb_mode_decode u_decode (
        .mode_i      (mode),
        .pin_i       (pin_s),
        .force_off_o (force_off)
    );

    swb_lampout_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .force_off_i (force_off),
        .lamp_en_i   (en_q),
        .cur_seen_i  (cur_seen_i),
        .tick_i      (tick_i),
        .lamp_ok_o   (stat.lamp_ok)
    );

    swb_oc_status u_oc (
        .clk        (clk),
        .rst        (rst),
        .oc_pulse_i (oc_pulse_i),
        .pwm_edge_i (pwm_edge_i),
        .no_oc_o    (stat.no_oc)
    );

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= ~force_off & stat.lamp_ok;
    end

    assign lamp_en_o = en_q;
    assign lamp_ok_o = stat.lamp_ok;
    assign no_oc_o   = stat.no_oc;

    AST_FORCED_DARK: assert property (@(posedge clk) disable iff (rst)
        force_off |=> !lamp_en_o); // R1
    AST_HARD_OFF: assert property (@(posedge clk) disable iff (rst)
        mode_i[2] |=> !lamp_en_o); // R1
    AST_FAULT_DARK: assert property (@(posedge clk) disable iff (rst)
        !lamp_ok_o |=> !lamp_en_o); // R5
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (lamp_ok_o && no_oc_o && !lamp_en_o)); // R7

endmodule

// File: tb/swb_lamp_guard_tb.sv
module swb_lamp_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICKS      = 8;
    localparam int WD_CYCLES  = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sus_pin = 1'b0;
    logic [2:0] mode = 3'b000;
    logic       cur_seen = 1'b0;
    logic       oc_pulse = 1'b0;
    logic       pwm_edge = 1'b0;
    logic       tick = 1'b0;
    logic       lamp_en, lamp_ok, no_oc;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swb_lamp_guard #(.SYNC_STAGES(2), .TIMEOUT_TICKS(TICKS)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .sus_pin_i  (sus_pin),
        .mode_i     (mode),
        .cur_seen_i (cur_seen),
        .oc_pulse_i (oc_pulse),
        .pwm_edge_i (pwm_edge),
        .tick_i     (tick),
        .lamp_en_o  (lamp_en),
        .lamp_ok_o  (lamp_ok),
        .no_oc_o    (no_oc)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; cyc(1);
            tick = 1'b0; cyc(2);
        end
    endtask

    // force off briefly to re-arm status and clear the tick count, then run
    task automatic rearm_run();
        sus_pin = 1'b0; mode = 3'b100; cyc(4);
        mode = 3'b000; cyc(2);
    endtask

    task automatic t_reset();
        rst = 1'b1; cyc(3);
        chk("R7", "lamp_ok in reset", lamp_ok, 1'b1);
        chk("R7", "no_oc in reset", no_oc, 1'b1);
        chk("R7", "lamp_en in reset", lamp_en, 1'b0);
        rst = 1'b0; cyc(1);
        chk("R7", "lamp_en one edge after reset, pin 0 mode 000", lamp_en, 1'b1);
    endtask

    task automatic t_mode_table();
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 8; m++) begin
                logic [2:0] mv;
                logic exp_en;
                mv = 3'(m);
                sus_pin = p[0]; mode = mv; cyc(4);
                exp_en = !(mv[2] | (p[0] & mv[1]) | (!p[0] & mv[0]));
                chk("R1", $sformatf("enable pin=%0d mode=%03b", p, mv), lamp_en, exp_en);
            end
        end
    endtask

    task automatic t_latency();
        sus_pin = 1'b0; mode = 3'b000; cyc(4);
        mode = 3'b001; cyc(1);
        chk("R1", "mode change seen after one edge", lamp_en, 1'b0);
        mode = 3'b010; cyc(1);
        chk("R1", "mode release after one edge", lamp_en, 1'b1);
        sus_pin = 1'b1; cyc(1);
        chk("R1", "pin edge +1", lamp_en, 1'b1);
        cyc(1);
        chk("R1", "pin edge +2", lamp_en, 1'b1);
        cyc(1);
        chk("R1", "pin edge +3", lamp_en, 1'b0);
        sus_pin = 1'b0; cyc(3);
    endtask

    task automatic t_timeout();
        rearm_run();
        do_ticks(TICKS - 1);
        chk("R4", "one tick short keeps ok", lamp_ok, 1'b1);
        tick = 1'b1; cyc(1); tick = 1'b0;
        chk("R3", "ok clears at last tick", lamp_ok, 1'b0);
        chk("R3", "enable still high same cycle", lamp_en, 1'b1);
        cyc(1);
        chk("R3", "enable drops one edge later", lamp_en, 1'b0);
    endtask

    task automatic t_cur_restart();
        rearm_run();
        do_ticks(TICKS - 1);
        cur_seen = 1'b1; cyc(1); cur_seen = 1'b0;
        do_ticks(TICKS - 1);
        chk("R4", "current strobe restarted count", lamp_ok, 1'b1);
        do_ticks(1);
        chk("R4", "full window after strobe clears ok", lamp_ok, 1'b0);
    endtask

    task automatic t_sticky_rearm();
        // lamp_ok is 0 here from the previous task
        cur_seen = 1'b1; cyc(3); cur_seen = 1'b0;
        chk("R5", "ok stays low despite current", lamp_ok, 1'b0);
        chk("R5", "enable stays low while fault", lamp_en, 1'b0);
        // re-arm by pin: pin high with mode bit 1
        mode = 3'b010; sus_pin = 1'b1; cyc(4);
        chk("R2", "pin forced off sets ok", lamp_ok, 1'b1);
        sus_pin = 1'b0; cyc(4);
        chk("R2", "lamp runs after re-arm", lamp_en, 1'b1);
        mode = 3'b000; cyc(2);
    endtask

    task automatic t_disable_restart();
        rearm_run();
        do_ticks(TICKS - 1);
        mode = 3'b001; cyc(3); mode = 3'b000; cyc(2);
        do_ticks(TICKS - 1);
        chk("R4", "disable restarted count", lamp_ok, 1'b1);
    endtask

    task automatic t_overcurrent();
        pwm_edge = 1'b1; cyc(1); pwm_edge = 1'b0; cyc(2);
        chk("R6", "clean period publishes 1", no_oc, 1'b1);
        oc_pulse = 1'b1; cyc(1); oc_pulse = 1'b0; cyc(2);
        chk("R6", "mid-period pulse does not change status", no_oc, 1'b1);
        pwm_edge = 1'b1; cyc(1); pwm_edge = 1'b0;
        chk("R6", "pulse in period publishes 0", no_oc, 1'b0);
        cyc(3);
        chk("R6", "status holds through period", no_oc, 1'b0);
        pwm_edge = 1'b1; cyc(1); pwm_edge = 1'b0;
        chk("R8", "record cleared, next period clean", no_oc, 1'b1);
        cyc(2);
        pwm_edge = 1'b1; oc_pulse = 1'b1; cyc(1); pwm_edge = 1'b0; oc_pulse = 1'b0;
        chk("R6", "pulse at boundary counts for ending period", no_oc, 1'b0);
        cyc(2);
        pwm_edge = 1'b1; cyc(1); pwm_edge = 1'b0;
        chk("R8", "boundary pulse does not leak forward", no_oc, 1'b1);
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_mode_table();
        t_latency();
        t_timeout();
        t_cur_restart();
        t_sticky_rearm();
        t_disable_restart();
        t_overcurrent();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule